// File: doc/BRIEF.md
# Infrared Carrier Envelope Demodulator

This block sits behind an infrared receiver whose output is active-low and asynchronous to the system clock. When the transmitter's slow on/off carrier is on, the receiver output toggles as a square wave of about 60 Hz with a 50% duty cycle. When the carrier is off, the output rests high. The block turns this high-or-oscillating waveform into one clean level: high while the carrier is present and low while it is absent. The level does not drop during the low half-cycles of the carrier. Later logic can then time the carrier gaps from a glitch-free signal.

The raw input first passes through a two-flop synchroniser. A free-running prescaler then produces a processing tick once every 2^PRESCALE_BITS clocks. Setting SIM_MODE forces the tick on every clock, so a bench can run at full speed. A small state machine runs on that tick. It has three states:

- CAR_ABSENT, with the output low.
- CAR_QUALIFY, where low samples are counted.
- CAR_PRESENT, with the output high.

The machine moves between them on these transitions:

- First low (CAR_ABSENT to CAR_QUALIFY): the first low sample starts qualification.
- Qualification abort (CAR_QUALIFY to CAR_ABSENT): a high sample arrives before CONFIRM_TICKS consecutive low samples have been seen.
- Confirm (CAR_QUALIFY to CAR_PRESENT): CONFIRM_TICKS consecutive low samples have been seen.
- Timeout (CAR_PRESENT to CAR_ABSENT): the missing-pulse timer runs out.

In CAR_PRESENT, every low sample reloads the missing-pulse timer to TIMEOUT_TICKS, and every high sample counts it down. TIMEOUT_TICKS should cover one carrier period plus some margin. It must also stay well below the shortest carrier-off gap that has to be resolved. A power-on reset generator inside the block clears all state, so the only ports are a clock, the raw input and the output.

Top module: `ird_envelope`

## Requirements
- R1: The raw input reaches the detector only through two clocked stages. With SIM_MODE set, a low first driven before clock edge 0 cannot affect the output through edge 2.
- R2: After power-up, the output is low and the missing-pulse timer is zero. The output stays low while the input rests high.
- R3: A low level seen on only one processing tick, followed by a high sample, leaves the output low (CAR_QUALIFY back to CAR_ABSENT).
- R4: With CONFIRM_TICKS = 2 and SIM_MODE set, a low held from before edge 0 drives the output high after edge 3 (CAR_ABSENT, then CAR_QUALIFY, then CAR_PRESENT).
- R5: In CAR_PRESENT, a carrier whose half-period is shorter than TIMEOUT_TICKS ticks keeps the output high on every cycle. Each low sample reloads the timer to TIMEOUT_TICKS.
- R6: Once the input goes high and stays high, the output drops on the TIMEOUT_TICKS-th tick that samples high. With SIM_MODE set and the input driven high before edge 0, the output is still high after edge TIMEOUT_TICKS and low after edge TIMEOUT_TICKS+1.
- R7: A single low sample arriving while the timer is nearly expired restores the full timeout. Counting from the edge that samples it, the output then falls only after a further TIMEOUT_TICKS ticks.
- R8: With SIM_MODE clear, state changes only on a prescaler tick, which comes once every 2^PRESCALE_BITS clocks. A low lasting fewer clocks than one tick period cannot raise the output. A long low raises it, and the release is held for TIMEOUT_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| ir_raw_n | input | 1 | Raw active-low receiver output, asynchronous |
| carrier_on | output | 1 | High while the carrier is detected |

## Verification
Every result has a fixed latency in clock edges, counted from the falling clock edge where the bench changes the input. The first low sample reaches the state machine at edge 2 and the output rises after edge 3. A release, or a one-cycle reload pulse, shows up as a fall after edge TIMEOUT_TICKS+1, counted from the edge after the last high drive. The bench therefore drives and samples only on falling edges, and checks the value both one edge before and at the edge where each change is due. For the prescaled instance the tick phase is not known. Its checks are therefore placed at clock counts that bound the number of ticks from above and below.

// File: rtl/ird_pkg.sv
package ird_pkg;

    typedef enum logic [1:0] {
        CAR_ABSENT  = 2'd0,
        CAR_QUALIFY = 2'd1,
        CAR_PRESENT = 2'd2
    } car_state_e;

endpackage

// File: rtl/ird_sync.sv
module ird_sync #(
    parameter int STAGES     = 2,
    parameter bit RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_LEVEL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ird_tick.sv
module ird_tick #(
    parameter int PRESCALE_BITS = 15,
    parameter bit SIM_MODE      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    logic [PRESCALE_BITS-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        if (SIM_MODE) begin : g_bypass
            assign tick_o = (div_q == div_q);
        end else begin : g_divided
            assign tick_o = (div_q == '0);
        end
    endgenerate

endmodule

// File: rtl/ird_detect.sv
module ird_detect
    import ird_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 25,
    parameter int CONFIRM_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic level_i,
    output logic present_o
);

    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam int RW = $clog2(CONFIRM_TICKS + 1);
    localparam logic [TW-1:0] T_FULL = TW'(TIMEOUT_TICKS);
    localparam logic [TW-1:0] T_ONE  = TW'(1);
    localparam logic [RW-1:0] R_LAST = RW'(CONFIRM_TICKS - 1);

    car_state_e      state_q, state_d;
    logic [TW-1:0]   timer_q, timer_d;
    logic [RW-1:0]   run_q, run_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAR_ABSENT;
            timer_q <= '0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            run_q   <= run_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        run_d   = run_q;
        if (tick_i) begin
            unique case (state_q)
                CAR_ABSENT: begin
                    if (!level_i) begin
                        run_d   = RW'(1);
                        state_d = CAR_QUALIFY;
                    end
                end
                CAR_QUALIFY: begin
                    if (level_i) begin
                        run_d   = '0;
                        state_d = CAR_ABSENT;
                    end else if (run_q == R_LAST) begin
                        run_d   = '0;
                        timer_d = T_FULL;
                        state_d = CAR_PRESENT;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                CAR_PRESENT: begin
                    if (!level_i) begin
                        timer_d = T_FULL;
                    end else if (timer_q == T_ONE) begin
                        timer_d = '0;
                        state_d = CAR_ABSENT;
                    end else begin
                        timer_d = timer_q - 1'b1;
                    end
                end
                default: begin
                    timer_d = '0;
                    run_d   = '0;
                    state_d = CAR_ABSENT;
                end
            endcase
        end
    end

    // Output process
    always_comb begin
        present_o = (state_q == CAR_PRESENT);
    end

    // R6
    present_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAR_PRESENT) |-> (timer_q != '0));

    // R2
    idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CAR_PRESENT) |-> (timer_q == '0));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !level_i && state_q == CAR_PRESENT) |=> (timer_q == T_FULL));

    // R3
    entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present_o) |-> ($past(state_q) == CAR_QUALIFY));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(state_q));

    // R7
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q <= T_FULL);

endmodule

// File: rtl/ird_envelope.sv
module ird_envelope #(
    parameter bit SIM_MODE      = 1'b0,
    parameter int PRESCALE_BITS = 15,
    parameter int TIMEOUT_TICKS = 25,
    parameter int CONFIRM_TICKS = 2,
    parameter int POR_BITS      = 4
) (
    input  logic clk_i,
    input  logic ir_raw_n,
    output logic carrier_on
);

    logic [POR_BITS-1:0] por_q = '0;
    logic                rst_n;
    logic                sample;
    logic                tick;

    always_ff @(posedge clk_i) begin
        por_q <= {por_q[POR_BITS-2:0], 1'b1};
    end

    assign rst_n = por_q[POR_BITS-1];

    ird_sync #(
        .STAGES      (2),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk     (clk_i),
        .rst_n   (rst_n),
        .async_i (ir_raw_n),
        .sync_o  (sample)
    );

    ird_tick #(
        .PRESCALE_BITS (PRESCALE_BITS),
        .SIM_MODE      (SIM_MODE)
    ) u_tick (
        .clk    (clk_i),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ird_detect #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .CONFIRM_TICKS (CONFIRM_TICKS)
    ) u_detect (
        .clk       (clk_i),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .level_i   (sample),
        .present_o (carrier_on)
    );

    // R2
    por_low_chk: assert property (@(posedge clk_i)
        !rst_n |=> !carrier_on);

endmodule

// File: tb/tb_ird_envelope.sv
module tb_ird_envelope;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 6;
    localparam int PBITS      = 3;

    logic clk = 1'b0;
    logic raw = 1'b1;
    logic raw_slow = 1'b1;
    logic out;
    logic out_slow;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ird_envelope #(
        .SIM_MODE (1'b1), .PRESCALE_BITS (PBITS),
        .TIMEOUT_TICKS (TMO), .CONFIRM_TICKS (2), .POR_BITS (4)
    ) dut (
        .clk_i (clk), .ir_raw_n (raw), .carrier_on (out)
    );

    ird_envelope #(
        .SIM_MODE (1'b0), .PRESCALE_BITS (PBITS),
        .TIMEOUT_TICKS (TMO), .CONFIRM_TICKS (2), .POR_BITS (4)
    ) dut_slow (
        .clk_i (clk), .ir_raw_n (raw_slow), .carrier_on (out_slow)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        edges(2);
        check("R2", out, 1'b0);
        check("R2", out_slow, 1'b0);
        edges(10);
        check("R2", out, 1'b0);
        check("R2", out_slow, 1'b0);
    endtask

    task automatic t_single_low();
        raw = 1'b0;
        edges(1);
        raw = 1'b1;
        for (int i = 0; i < 8; i++) begin
            edges(1);
            check("R3", out, 1'b0);
        end
    endtask

    task automatic t_rise();
        raw = 1'b0;
        edges(3);
        check("R1", out, 1'b0);
        edges(1);
        check("R4", out, 1'b1);
        edges(2);
    endtask

    task automatic t_square();
        for (int h = 0; h < 10; h++) begin
            raw = ~raw;
            for (int i = 0; i < 4; i++) begin
                edges(1);
                check("R5", out, 1'b1);
            end
        end
        raw = 1'b0;
        edges(3);
    endtask

    task automatic t_fall();
        raw = 1'b1;
        edges(TMO + 1);
        check("R6", out, 1'b1);
        edges(1);
        check("R6", out, 1'b0);
    endtask

    task automatic t_reload();
        raw = 1'b0;
        edges(6);
        check("R7", out, 1'b1);
        raw = 1'b1;
        edges(TMO - 3);
        raw = 1'b0;
        edges(1);
        raw = 1'b1;
        edges(TMO + 1);
        check("R7", out, 1'b1);
        edges(1);
        check("R7", out, 1'b0);
    endtask

    task automatic t_prescaled();
        raw_slow = 1'b0;
        edges(5);
        raw_slow = 1'b1;
        for (int i = 0; i < 6; i++) begin
            edges(10);
            check("R8", out_slow, 1'b0);
        end
        raw_slow = 1'b0;
        edges(40);
        check("R8", out_slow, 1'b1);
        raw_slow = 1'b1;
        edges(30);
        check("R8", out_slow, 1'b1);
        edges(40);
        check("R8", out_slow, 1'b0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_low();
        t_rise();
        t_square();
        t_fall();
        t_reload();
        t_prescaled();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule